// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block is a parameterized, fully associative array of address translations. Each slot holds a page base address, a partition number, a context number, a real-mode flag, a 2-bit page size code, a lock flag and a data word that carries the translation. A lookup compares one request against every slot at once. It returns hit, slot index and data word from registers one cycle later. Lookups run alongside the maintenance commands.

The commands are insert, demap and invalidate-all. Insert places a new translation. The slot is chosen by per-slot used bits, which are cleared in bulk when they would all be set. Locked slots keep their used bit through that clearing. Demap removes one page, one context, or every unlocked slot of a partition. Invalidate-all empties the array. A diagnostic port reads any slot's data word and a packed tag word without disturbing state. Page-table walking and miss handling belong to the surrounding logic.

Top module: `tlb_array`

## Requirements
- R1: After reset every slot reads invalid with its used bit clear, and `lk_hit` is 0.
- R2: A lookup hits a slot when all of these hold. The slot is valid. The request address equals the slot base above the page offset. Partition, context and real flag are equal. The size code sets the page offset: 0 is 8 KB (13 bits), 1 is 64 KB (16 bits), 2 is 4 MB (22 bits) and 3 is 256 MB (28 bits). `lk_hit`, `lk_idx` and `lk_data` appear on the cycle after `lk_req`. They reflect the array as it was before any command in the same cycle.
- R3: Insert writes the lowest-indexed slot that is invalid or has its used bit clear. If there is none, it writes the last slot. The written slot becomes valid and used. Its stored base is the address with the page offset cleared.
- R4: On insert, every valid slot with the same partition, context and real flag is invalidated and its used bit cleared, if its page overlaps the new page. Overlap is judged at the larger of the two page sizes. The new slot is then written.
- R5: A lookup hit or an insert may leave every used bit set. In that case the used bits of unlocked slots are cleared, and the slot just touched keeps its used bit. Used bits are never set on invalid slots.
- R6: Demap with `dm_kind` 0 (page) invalidates the slots that the demap fields would hit under the rules of R2. Their used bits are cleared.
- R7: Demap with `dm_kind` 1 (context) invalidates every valid slot whose partition and context both match, locked or not.
- R8: Demap with `dm_kind` 2 (partition) invalidates every unlocked slot of the partition. Locked slots stay valid.
- R9: Invalidate-all clears every slot's valid and used bits.
- R10: When commands coincide, invalidate-all wins over demap and demap wins over insert. The losing commands have no effect. A lookup's used-bit update is dropped in a cycle that carries any command.
- R11: The diagnostic port is combinational from the array. For slot `rd_idx` it gives the valid bit, the used bit and the data word, plus a 64-bit tag. In the tag, bits 63:61 hold the partition, bit 60 the real flag and bits 57:56 the inverted size code. The base address is ORed with the context in the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_part | input | 3 | Lookup partition |
| lk_ctx | input | 13 | Lookup context |
| lk_real | input | 1 | Lookup real-mode flag |
| lk_hit | output | 1 | Registered lookup hit |
| lk_idx | output | IDX_W | Registered hit slot index |
| lk_data | output | DATA_W | Registered data word of the hit slot |
| cmd_inval_all | input | 1 | Invalidate every slot |
| cmd_demap | input | 1 | Demap command |
| dm_kind | input | 2 | 0 page, 1 context, 2 partition, 3 no effect |
| dm_va | input | VA_W | Demap address (page kind) |
| dm_part | input | 3 | Demap partition |
| dm_ctx | input | 13 | Demap context |
| dm_real | input | 1 | Demap real flag (page kind) |
| cmd_insert | input | 1 | Insert command |
| ins_va | input | VA_W | Insert address |
| ins_part | input | 3 | Insert partition |
| ins_ctx | input | 13 | Insert context |
| ins_real | input | 1 | Insert real flag |
| ins_size | input | 2 | Insert page size code |
| ins_lock | input | 1 | Insert as locked |
| ins_data | input | DATA_W | Insert data word |
| rd_idx | input | IDX_W | Diagnostic slot index |
| rd_valid | output | 1 | Valid bit of slot `rd_idx` |
| rd_used | output | 1 | Used bit of slot `rd_idx` |
| rd_data | output | DATA_W | Data word of slot `rd_idx` |
| rd_tag | output | 64 | Packed tag word of slot `rd_idx` |

## Verification
Some corners are hard to reach from the ports. One is the array in which every slot is both locked and used, where insert must fall back to the last slot. Another is the bulk clearing of used bits, which keeps a locked slot marked. The bench reaches both with a small build of eight slots. It fills every slot by insertion, once with one locked slot and once with all slots locked. It then reads each used bit through the diagnostic port. Further inserts and a lookup in between show where replacement lands next.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int PART_W       = 3;
    localparam int CTX_W        = 13;
    localparam int SIZE_W       = 2;
    localparam int TAG_W        = 64;
    localparam int TAG_PART_LSB = 61;
    localparam int TAG_REAL_BIT = 60;
    localparam int TAG_SIZE_LSB = 56;

    typedef enum logic [1:0] {
        DM_PAGE = 2'd0,
        DM_CTX  = 2'd1,
        DM_PART = 2'd2,
        DM_NONE = 2'd3
    } demap_kind_e;

    // Number of page-offset bits for each size code.
    function automatic int unsigned pg_shift(input logic [SIZE_W-1:0] sz);
        case (sz)
            2'd0:    return 13;
            2'd1:    return 16;
            2'd2:    return 22;
            default: return 28;
        endcase
    endfunction

endpackage

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
    parameter  int N     = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             found
);

    // Scan from the top so the lowest set bit is the last written.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
    import tlb_pkg::*;
#(
    parameter int VA_W = 48
) (
    input  logic              e_valid,
    input  logic              e_lock,
    input  logic [VA_W-1:0]   e_va,
    input  logic [PART_W-1:0] e_part,
    input  logic [CTX_W-1:0]  e_ctx,
    input  logic              e_real,
    input  logic [SIZE_W-1:0] e_size,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [PART_W-1:0] lk_part,
    input  logic [CTX_W-1:0]  lk_ctx,
    input  logic              lk_real,
    input  logic [VA_W-1:0]   dm_va,
    input  logic [PART_W-1:0] dm_part,
    input  logic [CTX_W-1:0]  dm_ctx,
    input  logic              dm_real,
    input  logic [VA_W-1:0]   ins_va,
    input  logic [PART_W-1:0] ins_part,
    input  logic [CTX_W-1:0]  ins_ctx,
    input  logic              ins_real,
    input  logic [SIZE_W-1:0] ins_size,
    output logic              lk_hit,
    output logic              dm_page_hit,
    output logic              dm_ctx_hit,
    output logic              dm_part_hit,
    output logic              ins_clash
);

    function automatic logic [VA_W-1:0] hi_mask(input logic [SIZE_W-1:0] sz);
        return ~((VA_W'(1) << pg_shift(sz)) - VA_W'(1));
    endfunction

    logic [VA_W-1:0] e_mask;
    logic [VA_W-1:0] big_mask;

    assign e_mask   = hi_mask(e_size);
    // The larger page has fewer high-mask bits, so AND keeps the coarser compare.
    assign big_mask = e_mask & hi_mask(ins_size);

    assign lk_hit = e_valid && ((lk_va & e_mask) == e_va) &&
                    (lk_part == e_part) && (lk_ctx == e_ctx) && (lk_real == e_real);

    assign dm_page_hit = e_valid && ((dm_va & e_mask) == e_va) &&
                         (dm_part == e_part) && (dm_ctx == e_ctx) && (dm_real == e_real);

    assign dm_ctx_hit  = e_valid && (dm_part == e_part) && (dm_ctx == e_ctx);

    assign dm_part_hit = e_valid && !e_lock && (dm_part == e_part);

    assign ins_clash = e_valid && ((ins_va & big_mask) == (e_va & big_mask)) &&
                       (ins_part == e_part) && (ins_ctx == e_ctx) && (ins_real == e_real);

endmodule

// File: rtl/tlb_array.sv
module tlb_array
    import tlb_pkg::*;
#(
    parameter  int ENTRIES = 64,
    parameter  int VA_W    = 48,
    parameter  int DATA_W  = 64,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [PART_W-1:0] lk_part,
    input  logic [CTX_W-1:0]  lk_ctx,
    input  logic              lk_real,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [DATA_W-1:0] lk_data,
    input  logic              cmd_inval_all,
    input  logic              cmd_demap,
    input  logic [1:0]        dm_kind,
    input  logic [VA_W-1:0]   dm_va,
    input  logic [PART_W-1:0] dm_part,
    input  logic [CTX_W-1:0]  dm_ctx,
    input  logic              dm_real,
    input  logic              cmd_insert,
    input  logic [VA_W-1:0]   ins_va,
    input  logic [PART_W-1:0] ins_part,
    input  logic [CTX_W-1:0]  ins_ctx,
    input  logic              ins_real,
    input  logic [SIZE_W-1:0] ins_size,
    input  logic              ins_lock,
    input  logic [DATA_W-1:0] ins_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_used,
    output logic [DATA_W-1:0] rd_data,
    output logic [TAG_W-1:0]  rd_tag
);

    typedef struct packed {
        logic [ENTRIES-1:0]              valid;
        logic [ENTRIES-1:0]              used;
        logic [ENTRIES-1:0]              lock;
        logic [ENTRIES-1:0][VA_W-1:0]    va;
        logic [ENTRIES-1:0][PART_W-1:0]  part;
        logic [ENTRIES-1:0][CTX_W-1:0]   ctx;
        logic [ENTRIES-1:0]              rl;
        logic [ENTRIES-1:0][SIZE_W-1:0]  size;
        logic [ENTRIES-1:0][DATA_W-1:0]  data;
        logic                            lk_hit;
        logic [IDX_W-1:0]                lk_idx;
        logic [DATA_W-1:0]               lk_data;
    } state_t;

    state_t s_d, s_q;

    function automatic logic [VA_W-1:0] hi_mask(input logic [SIZE_W-1:0] sz);
        return ~((VA_W'(1) << pg_shift(sz)) - VA_W'(1));
    endfunction

    // Per-slot comparators
    logic [ENTRIES-1:0] lk_vec, dm_page_vec, dm_ctx_vec, dm_part_vec, clash_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        tlb_entry_cmp #(.VA_W(VA_W)) u_cmp (
            .e_valid     (s_q.valid[g]),
            .e_lock      (s_q.lock[g]),
            .e_va        (s_q.va[g]),
            .e_part      (s_q.part[g]),
            .e_ctx       (s_q.ctx[g]),
            .e_real      (s_q.rl[g]),
            .e_size      (s_q.size[g]),
            .lk_va       (lk_va),
            .lk_part     (lk_part),
            .lk_ctx      (lk_ctx),
            .lk_real     (lk_real),
            .dm_va       (dm_va),
            .dm_part     (dm_part),
            .dm_ctx      (dm_ctx),
            .dm_real     (dm_real),
            .ins_va      (ins_va),
            .ins_part    (ins_part),
            .ins_ctx     (ins_ctx),
            .ins_real    (ins_real),
            .ins_size    (ins_size),
            .lk_hit      (lk_vec[g]),
            .dm_page_hit (dm_page_vec[g]),
            .dm_ctx_hit  (dm_ctx_vec[g]),
            .dm_part_hit (dm_part_vec[g]),
            .ins_clash   (clash_vec[g])
        );
    end

    // Lowest hitting slot and lowest replaceable slot
    logic [IDX_W-1:0]   lk_first, vic_first, victim;
    logic               lk_found, vic_found;
    logic [ENTRIES-1:0] free_vec;

    assign free_vec = ~s_q.valid | ~s_q.used;

    tlb_first_set #(.N(ENTRIES)) u_lk_sel (
        .req   (lk_vec),
        .idx   (lk_first),
        .found (lk_found)
    );

    tlb_first_set #(.N(ENTRIES)) u_vic_sel (
        .req   (free_vec),
        .idx   (vic_first),
        .found (vic_found)
    );

    // With every slot locked and in use, the last slot is overwritten.
    assign victim = vic_found ? vic_first : IDX_W'(ENTRIES - 1);

    // Next-state logic
    logic               touch_en;
    logic [IDX_W-1:0]   touch;
    logic [ENTRIES-1:0] kill;

    always_comb begin
        s_d      = s_q;
        touch_en = 1'b0;
        touch    = '0;
        kill     = '0;

        s_d.lk_hit  = lk_req && lk_found;
        s_d.lk_idx  = lk_first;
        s_d.lk_data = s_q.data[lk_first];

        if (cmd_inval_all) begin
            s_d.valid = '0;
            s_d.used  = '0;
        end else if (cmd_demap) begin
            case (demap_kind_e'(dm_kind))
                DM_PAGE: kill = dm_page_vec;
                DM_CTX:  kill = dm_ctx_vec;
                DM_PART: kill = dm_part_vec;
                default: kill = '0;
            endcase
            s_d.valid = s_q.valid & ~kill;
            s_d.used  = s_q.used & ~kill;
        end else if (cmd_insert) begin
            s_d.valid          = s_q.valid & ~clash_vec;
            s_d.used           = s_q.used & ~clash_vec;
            s_d.valid[victim]  = 1'b1;
            s_d.used[victim]   = 1'b1;
            s_d.lock[victim]   = ins_lock;
            s_d.va[victim]     = ins_va & hi_mask(ins_size);
            s_d.part[victim]   = ins_part;
            s_d.ctx[victim]    = ins_ctx;
            s_d.rl[victim]     = ins_real;
            s_d.size[victim]   = ins_size;
            s_d.data[victim]   = ins_data;
            touch_en           = 1'b1;
            touch              = victim;
        end else if (lk_req && lk_found) begin
            s_d.used[lk_first] = 1'b1;
            touch_en           = 1'b1;
            touch              = lk_first;
        end

        // Saturation: drop unlocked used bits, keep the one just touched.
        if (touch_en && (&s_d.used)) begin
            s_d.used        = s_d.used & s_d.lock;
            s_d.used[touch] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lk_hit  = s_q.lk_hit;
    assign lk_idx  = s_q.lk_idx;
    assign lk_data = s_q.lk_data;

    // Diagnostic read; a range guard is only needed when the index space is sparse.
    logic rd_ok;

    if (ENTRIES == (1 << IDX_W)) begin : g_rd_full
        assign rd_ok = 1'b1;
    end else begin : g_rd_sparse
        assign rd_ok = (rd_idx < IDX_W'(ENTRIES));
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_used  = 1'b0;
        rd_data  = '0;
        rd_tag   = '0;
        if (rd_ok) begin
            rd_valid = s_q.valid[rd_idx];
            rd_used  = s_q.used[rd_idx];
            rd_data  = s_q.data[rd_idx];
            rd_tag[TAG_PART_LSB +: PART_W] = s_q.part[rd_idx];
            rd_tag[TAG_REAL_BIT]           = s_q.rl[rd_idx];
            rd_tag[TAG_SIZE_LSB +: SIZE_W] = ~s_q.size[rd_idx];
            rd_tag[VA_W-1:0]  = rd_tag[VA_W-1:0] | s_q.va[rd_idx];
            rd_tag[CTX_W-1:0] = rd_tag[CTX_W-1:0] | s_q.ctx[rd_idx];
        end
    end

    // Assertions

    // R5: a used bit never sits on an invalid slot
    p_used_on_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.used & ~s_q.valid) == '0);

    // R9: invalidate-all empties the array
    p_inval_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_inval_all |=> (s_q.valid == '0));

    // R2: a reported hit names a slot that was valid when looked up
    p_hit_was_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (!lk_hit || (|($past(s_q.valid) & (ENTRIES'(1) << lk_idx)))));

    // R3: an insert that wins arbitration leaves at least one valid slot
    p_insert_installs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_insert && !cmd_inval_all && !cmd_demap) |=> (s_q.valid != '0));

    // R10: a demap that coincides with insert never adds a slot
    p_demap_beats_insert_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_demap && !cmd_inval_all && cmd_insert) |=>
        ($countones(s_q.valid) <= $countones($past(s_q.valid))));

    // R8: a partition demap keeps every locked valid slot
    p_part_keeps_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_demap && !cmd_inval_all && dm_kind == 2'd2) |=>
        ((s_q.valid & $past(s_q.valid & s_q.lock)) == $past(s_q.valid & s_q.lock)));

endmodule

// File: tb/test_tlb_array.sv
`timescale 1ns/1ps
module test_tlb_array;

    localparam int N      = 8;
    localparam int VA_W   = 48;
    localparam int DATA_W = 64;
    localparam int IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_req = 1'b0;
    logic [VA_W-1:0]   lk_va = '0;
    logic [2:0]        lk_part = '0;
    logic [12:0]       lk_ctx = '0;
    logic              lk_real = 1'b0;
    logic              lk_hit;
    logic [IDX_W-1:0]  lk_idx;
    logic [DATA_W-1:0] lk_data;
    logic              cmd_inval_all = 1'b0;
    logic              cmd_demap = 1'b0;
    logic [1:0]        dm_kind = '0;
    logic [VA_W-1:0]   dm_va = '0;
    logic [2:0]        dm_part = '0;
    logic [12:0]       dm_ctx = '0;
    logic              dm_real = 1'b0;
    logic              cmd_insert = 1'b0;
    logic [VA_W-1:0]   ins_va = '0;
    logic [2:0]        ins_part = '0;
    logic [12:0]       ins_ctx = '0;
    logic              ins_real = 1'b0;
    logic [1:0]        ins_size = '0;
    logic              ins_lock = 1'b0;
    logic [DATA_W-1:0] ins_data = '0;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic              rd_valid;
    logic              rd_used;
    logic [DATA_W-1:0] rd_data;
    logic [63:0]       rd_tag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tlb_array #(.ENTRIES(N), .VA_W(VA_W), .DATA_W(DATA_W)) i_tlb_array (
        .clk, .rst_n,
        .lk_req, .lk_va, .lk_part, .lk_ctx, .lk_real,
        .lk_hit, .lk_idx, .lk_data,
        .cmd_inval_all,
        .cmd_demap, .dm_kind, .dm_va, .dm_part, .dm_ctx, .dm_real,
        .cmd_insert, .ins_va, .ins_part, .ins_ctx, .ins_real, .ins_size, .ins_lock, .ins_data,
        .rd_idx, .rd_valid, .rd_used, .rd_data, .rd_tag
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        lk_req = 1'b0; cmd_inval_all = 1'b0; cmd_demap = 1'b0; cmd_insert = 1'b0;
    endtask

    task automatic set_ins(input logic [47:0] va, input logic [2:0] part, input logic [12:0] ctx,
                           input logic rl, input logic [1:0] sz, input logic lk, input logic [63:0] d);
        cmd_insert = 1'b1; ins_va = va; ins_part = part; ins_ctx = ctx;
        ins_real = rl; ins_size = sz; ins_lock = lk; ins_data = d;
    endtask

    task automatic set_dm(input logic [1:0] kind, input logic [47:0] va, input logic [2:0] part,
                          input logic [12:0] ctx, input logic rl);
        cmd_demap = 1'b1; dm_kind = kind; dm_va = va; dm_part = part; dm_ctx = ctx; dm_real = rl;
    endtask

    task automatic set_lk(input logic [47:0] va, input logic [2:0] part, input logic [12:0] ctx, input logic rl);
        lk_req = 1'b1; lk_va = va; lk_part = part; lk_ctx = ctx; lk_real = rl;
    endtask

    task automatic ins(input logic [47:0] va, input logic [2:0] part, input logic [12:0] ctx,
                       input logic rl, input logic [1:0] sz, input logic lk, input logic [63:0] d);
        set_ins(va, part, ctx, rl, sz, lk, d); tick(); idle();
    endtask

    task automatic dmap(input logic [1:0] kind, input logic [47:0] va, input logic [2:0] part,
                        input logic [12:0] ctx, input logic rl);
        set_dm(kind, va, part, ctx, rl); tick(); idle();
    endtask

    task automatic inval();
        cmd_inval_all = 1'b1; tick(); idle();
    endtask

    task automatic look(input logic [47:0] va, input logic [2:0] part, input logic [12:0] ctx, input logic rl);
        set_lk(va, part, ctx, rl); tick(); idle();
    endtask

    task automatic chk_slot(input string req, input int idx, input logic v, input logic u);
        rd_idx = IDX_W'(idx);
        #0.1;
        chk(req, $sformatf("slot %0d valid", idx), 64'(rd_valid), 64'(v));
        chk(req, $sformatf("slot %0d used", idx), 64'(rd_used), 64'(u));
    endtask

    function automatic logic [63:0] exp_tag(input logic [47:0] va, input logic [2:0] part,
                                            input logic [12:0] ctx, input logic rl, input logic [1:0] sz);
        int sh;
        logic [63:0] t;
        sh = (sz == 2'd0) ? 13 : (sz == 2'd1) ? 16 : (sz == 2'd2) ? 22 : 28;
        t = {part, rl, 2'b00, ~sz, 56'd0};
        t = t | (64'(va) & ~((64'd1 << sh) - 64'd1)) | 64'(ctx);
        return t;
    endfunction

    task automatic chk_tag(input string req, input int idx, input logic [63:0] exp);
        rd_idx = IDX_W'(idx);
        #0.1;
        chk(req, $sformatf("slot %0d tag", idx), rd_tag, exp);
    endtask

    // Scenarios

    task automatic t_reset();
        for (int i = 0; i < N; i++) chk_slot("R1", i, 1'b0, 1'b0);
        chk("R1", "lk_hit after reset", 64'(lk_hit), 64'd0);
        look(48'h0, 3'd0, 13'd0, 1'b0);
        chk("R1", "lookup in empty array", 64'(lk_hit), 64'd0);
    endtask

    task automatic t_lookup();
        inval();
        ins(48'h0000_1234_5678, 3'd1, 13'd7, 1'b0, 2'd1, 1'b0, 64'hA1);
        look(48'h0000_1234_FFF8, 3'd1, 13'd7, 1'b0);
        chk("R2", "64K hit", 64'(lk_hit), 64'd1);
        chk("R2", "64K hit idx", 64'(lk_idx), 64'd0);
        chk("R2", "64K hit data", lk_data, 64'hA1);
        look(48'h0000_1235_0000, 3'd1, 13'd7, 1'b0);
        chk("R2", "beyond page miss", 64'(lk_hit), 64'd0);
        look(48'h0000_1234_0000, 3'd1, 13'd6, 1'b0);
        chk("R2", "context mismatch", 64'(lk_hit), 64'd0);
        look(48'h0000_1234_0000, 3'd2, 13'd7, 1'b0);
        chk("R2", "partition mismatch", 64'(lk_hit), 64'd0);
        look(48'h0000_1234_0000, 3'd1, 13'd7, 1'b1);
        chk("R2", "real flag mismatch", 64'(lk_hit), 64'd0);
        ins(48'h0000_5000_0000, 3'd1, 13'd2, 1'b0, 2'd3, 1'b0, 64'hA2);
        look(48'h0000_5FFF_FFF8, 3'd1, 13'd2, 1'b0);
        chk("R2", "256M hit", 64'(lk_hit), 64'd1);
        chk("R2", "256M hit idx", 64'(lk_idx), 64'd1);
        look(48'h0000_6000_0000, 3'd1, 13'd2, 1'b0);
        chk("R2", "256M next page miss", 64'(lk_hit), 64'd0);
        chk_tag("R11", 0, exp_tag(48'h0000_1234_5678, 3'd1, 13'd7, 1'b0, 2'd1));
        chk_tag("R11", 1, exp_tag(48'h0000_5000_0000, 3'd1, 13'd2, 1'b0, 2'd3));
        rd_idx = 3'd1; #0.1;
        chk("R11", "slot 1 data", rd_data, 64'hA2);
    endtask

    task automatic t_victim();
        inval();
        for (int i = 0; i < 3; i++) ins(48'h2000 * (i + 1), 3'd0, 13'd1, 1'b0, 2'd0, 1'b0, 64'(i));
        chk_slot("R3", 2, 1'b1, 1'b1);
        chk_slot("R3", 3, 1'b0, 1'b0);
        chk_tag("R3", 1, exp_tag(48'h4000, 3'd0, 13'd1, 1'b0, 2'd0));
        dmap(2'd0, 48'h4010, 3'd0, 13'd1, 1'b0);
        chk_slot("R6", 1, 1'b0, 1'b0);
        chk_slot("R6", 0, 1'b1, 1'b1);
        ins(48'h9_0000, 3'd0, 13'd1, 1'b0, 2'd0, 1'b0, 64'h55);
        chk_tag("R3", 1, exp_tag(48'h9_0000, 3'd0, 13'd1, 1'b0, 2'd0));
    endtask

    task automatic t_saturate();
        inval();
        for (int i = 0; i < N; i++)
            ins(48'h1_0000 + 48'h2000 * i, 3'd0, 13'd1, 1'b0, 2'd0, i == 0, 64'(i));
        for (int i = 0; i < N; i++) chk_slot("R5", i, 1'b1, (i == 0) || (i == N - 1));
        ins(48'h3_0000, 3'd0, 13'd1, 1'b0, 2'd0, 1'b0, 64'h30);
        chk_tag("R3", 1, exp_tag(48'h3_0000, 3'd0, 13'd1, 1'b0, 2'd0));
        look(48'h1_4000, 3'd0, 13'd1, 1'b0);
        chk("R2", "lookup slot 2", 64'(lk_idx), 64'd2);
        chk_slot("R5", 2, 1'b1, 1'b1);
        ins(48'h3_2000, 3'd0, 13'd1, 1'b0, 2'd0, 1'b0, 64'h32);
        chk_tag("R3", 3, exp_tag(48'h3_2000, 3'd0, 13'd1, 1'b0, 2'd0));
    endtask

    task automatic t_all_locked();
        inval();
        for (int i = 0; i < N; i++)
            ins(48'h2_0000 + 48'h2000 * i, 3'd3, 13'd9, 1'b0, 2'd0, 1'b1, 64'(i));
        for (int i = 0; i < N; i++) chk_slot("R5", i, 1'b1, 1'b1);
        ins(48'h7_0000, 3'd3, 13'd9, 1'b0, 2'd0, 1'b0, 64'h77);
        chk_tag("R3", N - 1, exp_tag(48'h7_0000, 3'd3, 13'd9, 1'b0, 2'd0));
        chk_tag("R3", N - 2, exp_tag(48'h2_0000 + 48'h2000 * (N - 2), 3'd3, 13'd9, 1'b0, 2'd0));
    endtask

    task automatic t_clash();
        inval();
        ins(48'h10_0000, 3'd0, 13'd5, 1'b0, 2'd0, 1'b0, 64'h1);
        ins(48'h10_2000, 3'd0, 13'd5, 1'b0, 2'd0, 1'b0, 64'h2);
        ins(48'h10_0000, 3'd0, 13'd6, 1'b0, 2'd0, 1'b0, 64'h3);
        ins(48'h00_0000, 3'd0, 13'd5, 1'b0, 2'd2, 1'b0, 64'h4);
        chk_slot("R4", 0, 1'b0, 1'b0);
        chk_slot("R4", 1, 1'b0, 1'b0);
        chk_slot("R4", 2, 1'b1, 1'b1);
        chk_slot("R4", 3, 1'b1, 1'b1);
        look(48'h10_0008, 3'd0, 13'd5, 1'b0);
        chk("R4", "4M page serves old address idx", 64'(lk_idx), 64'd3);
        chk("R4", "4M page serves old address data", lk_data, 64'h4);
    endtask

    task automatic t_demap();
        inval();
        ins(48'h2000, 3'd1, 13'd3, 1'b0, 2'd0, 1'b0, 64'h0);
        ins(48'h4000, 3'd1, 13'd3, 1'b0, 2'd0, 1'b0, 64'h1);
        ins(48'h6000, 3'd1, 13'd4, 1'b0, 2'd0, 1'b1, 64'h2);
        ins(48'h8000, 3'd2, 13'd3, 1'b0, 2'd0, 1'b0, 64'h3);
        ins(48'hA000, 3'd1, 13'd5, 1'b0, 2'd0, 1'b0, 64'h4);
        dmap(2'd0, 48'h2008, 3'd1, 13'd3, 1'b0);
        chk_slot("R6", 0, 1'b0, 1'b0);
        chk_slot("R6", 1, 1'b1, 1'b1);
        dmap(2'd1, 48'h0, 3'd1, 13'd3, 1'b0);
        chk_slot("R7", 1, 1'b0, 1'b0);
        chk_slot("R7", 3, 1'b1, 1'b1);
        dmap(2'd2, 48'h0, 3'd1, 13'd0, 1'b0);
        chk_slot("R8", 4, 1'b0, 1'b0);
        chk_slot("R8", 2, 1'b1, 1'b1);
        chk_slot("R8", 3, 1'b1, 1'b1);
        dmap(2'd1, 48'h0, 3'd1, 13'd4, 1'b0);
        chk_slot("R7", 2, 1'b0, 1'b0);
    endtask

    task automatic t_inval();
        inval();
        for (int i = 0; i < N; i++) chk_slot("R9", i, 1'b0, 1'b0);
        look(48'h8000, 3'd2, 13'd3, 1'b0);
        chk("R9", "lookup after invalidate-all", 64'(lk_hit), 64'd0);
    endtask

    task automatic t_prio();
        int cnt;
        inval();
        ins(48'h5_0000, 3'd0, 13'd1, 1'b0, 2'd0, 1'b0, 64'hE);
        set_lk(48'h5_0000, 3'd0, 13'd1, 1'b0);
        cmd_inval_all = 1'b1;
        set_ins(48'h5_2000, 3'd0, 13'd1, 1'b0, 2'd0, 1'b0, 64'hF);
        tick(); idle();
        chk("R10", "lookup sees pre-command state", 64'(lk_hit), 64'd1);
        chk_slot("R10", 0, 1'b0, 1'b0);
        chk_slot("R10", 1, 1'b0, 1'b0);
        ins(48'h5_0000, 3'd0, 13'd1, 1'b0, 2'd0, 1'b0, 64'hE);
        set_dm(2'd0, 48'h5_0000, 3'd0, 13'd1, 1'b0);
        set_ins(48'h5_2000, 3'd0, 13'd1, 1'b0, 2'd0, 1'b0, 64'hF);
        tick(); idle();
        cnt = 0;
        for (int i = 0; i < N; i++) begin
            rd_idx = IDX_W'(i); #0.1;
            cnt += int'(rd_valid);
        end
        chk("R10", "insert dropped under demap", 64'(cnt), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lookup();
        t_victim();
        t_saturate();
        t_all_locked();
        t_clash();
        t_demap();
        t_inval();
        t_prio();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule